// File: doc/BRIEF.md
# Subword Atomic Read-Modify-Write Unit

This unit performs byte and halfword atomic memory operations on a memory organised as words. A request names an operation, a width code, a byte address, a source operand and, for compare-and-swap, a compare value. The unit runs one locked read of the containing word. It selects the addressed lane, computes the new lane value and writes only that lane back under byte enables. It then returns the old lane value, sign-extended to the full register width.

Requests are taken one at a time. The unit rejects a request with a misaligned address, an unknown operation code or an unsupported width code without touching memory, and it answers such a request with an error response. The two ordering bits that come with a request appear on the memory side during both accesses. Load-reserved and store-conditional at these widths are not part of the operation set.

Top module: `subword_amo_unit`

## Requirements
- R1: Operation codes: 00000 add, 00001 swap, 00100 xor, 01000 or, 01100 and, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max, 00101 compare-and-swap. Each code stores the matching function of the old lane and the source lane, and add wraps within the lane.
- R2: Width code 0 selects an 8-bit lane and width code 1 selects a 16-bit lane. Width codes 2 and 3 give an error response with no memory access.
- R3: A successful response carries the old lane value, sign-extended to XLEN bits, for every operation including unsigned min and max. An error response carries zero data.
- R4: Source bits above the lane width have no effect on the value that is stored.
- R5: Compare-and-swap compares only the low lane bits of the compare value with the old lane. On a match it stores the source lane. On a mismatch it performs no write and still returns the old lane.
- R6: A halfword request with address bit 0 set gives an error response with no memory access.
- R7: An operation code outside the R1 list gives an error response with no memory access.
- R8: A byte lane starts at byte address[1:0] of the word and a halfword lane at byte 2*address[1]. `mem_addr` is the request address with its low two bits cleared. A write asserts `mem_be` only for the lane bytes, and every other byte of the word stays unchanged.
- R9: A legal request makes exactly one read and then at most one write, with `mem_lock` high on both. `rsp_valid` rises three cycles after the accepting edge (one cycle for an error) and lasts one cycle. `req_ready` is high only while idle.
- R10: The request's aq and rl bits appear on `mem_aq` and `mem_rl` throughout its memory accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting |
| req_op | input | 5 | Operation code |
| req_width | input | 2 | Width code |
| req_addr | input | ADDR_W | Byte address |
| req_src | input | XLEN | Source operand |
| req_cmp | input | XLEN | Compare value for compare-and-swap |
| req_aq | input | 1 | Acquire ordering bit |
| req_rl | input | 1 | Release ordering bit |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Read-write pair in progress |
| mem_addr | output | ADDR_W | Word-aligned address |
| mem_be | output | WORD_W/8 | Byte enables |
| mem_wdata | output | WORD_W | Merged write word |
| mem_aq | output | 1 | Forwarded acquire bit |
| mem_rl | output | 1 | Forwarded release bit |
| mem_rdata | input | WORD_W | Read word, valid the cycle after a read |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request rejected |
| rsp_data | output | XLEN | Sign-extended old lane |

## Verification
The bench builds the unit with XLEN=64, WORD_W=32 and ADDR_W=10. With these values, a 64-bit result makes every sign-extension bit visible, and garbage in bits 16 to 63 of the source and compare operands can be driven. The bench drives every byte and halfword lane position of several words and compares each word against its own model after every request, so writes that stray into a neighbouring byte are caught.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'b00000,
    OP_SWAP = 5'b00001,
    OP_XOR  = 5'b00100,
    OP_CAS  = 5'b00101,
    OP_OR   = 5'b01000,
    OP_AND  = 5'b01100,
    OP_MIN  = 5'b10000,
    OP_MAX  = 5'b10100,
    OP_MINU = 5'b11000,
    OP_MAXU = 5'b11100
  } amo_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } amo_state_e;

  localparam logic [1:0] WID_BYTE = 2'd0;
  localparam logic [1:0] WID_HALF = 2'd1;

  typedef struct packed {
    logic        wr;
    logic [15:0] val;
  } lane_res_t;

  function automatic logic op_known(input logic [4:0] code);
    case (code)
      OP_ADD, OP_SWAP, OP_XOR, OP_CAS, OP_OR,
      OP_AND, OP_MIN, OP_MAX, OP_MINU, OP_MAXU: op_known = 1'b1;
      default:                                  op_known = 1'b0;
    endcase
  endfunction

  // New lane value from old lane, source and compare; the upper byte is
  // cleared for byte width.
  function automatic lane_res_t lane_calc(input amo_op_e op, input logic wide,
                                          input logic [15:0] old_l,
                                          input logic [15:0] src_l,
                                          input logic [15:0] cmp_l);
    logic [15:0] mask;
    logic [16:0] o_s, s_s, o_u, s_u;
    logic        lt_s, lt_u;
    lane_res_t   r;
    mask = wide ? 16'hFFFF : 16'h00FF;
    o_u  = {1'b0, old_l & mask};
    s_u  = {1'b0, src_l & mask};
    o_s  = wide ? {old_l[15], old_l} : {{9{old_l[7]}}, old_l[7:0]};
    s_s  = wide ? {src_l[15], src_l} : {{9{src_l[7]}}, src_l[7:0]};
    lt_s = $signed(o_s) < $signed(s_s);
    lt_u = o_u < s_u;
    r.wr = 1'b1;
    case (op)
      OP_ADD:  r.val = old_l + src_l;
      OP_SWAP: r.val = src_l;
      OP_XOR:  r.val = old_l ^ src_l;
      OP_OR:   r.val = old_l | src_l;
      OP_AND:  r.val = old_l & src_l;
      OP_MIN:  r.val = lt_s ? old_l : src_l;
      OP_MAX:  r.val = lt_s ? src_l : old_l;
      OP_MINU: r.val = lt_u ? old_l : src_l;
      OP_MAXU: r.val = lt_u ? src_l : old_l;
      OP_CAS: begin
        r.val = src_l;
        r.wr  = ((old_l ^ cmp_l) & mask) == 16'h0000;
      end
      default: begin
        r.val = old_l;
        r.wr  = 1'b0;
      end
    endcase
    r.val = r.val & mask;
    return r;
  endfunction

  function automatic logic [63:0] sext_lane(input logic [15:0] v, input logic wide);
    return wide ? {{48{v[15]}}, v} : {{56{v[7]}}, v[7:0]};
  endfunction

endpackage

// File: rtl/amo_req_check.sv
module amo_req_check (
  input  logic [4:0] op,
  input  logic [1:0] width,
  input  logic       addr_b0,
  output logic       bad_op,
  output logic       bad_width,
  output logic       misalign,
  output logic       wide
);
  import amo_pkg::*;

  always_comb begin
    bad_op    = !op_known(op);
    bad_width = (width != WID_BYTE) && (width != WID_HALF);
    wide      = (width == WID_HALF);
    misalign  = wide && addr_b0;
  end

endmodule

// File: rtl/amo_lane_path.sv
module amo_lane_path #(
  parameter int WORD_W = 32,
  localparam int BYTES = WORD_W / 8,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wide,
  input  logic [15:0]       new_lane,
  output logic [15:0]       old_lane,
  output logic [BYTES-1:0]  be,
  output logic [WORD_W-1:0] wdata
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted  = word >> {idx, 3'b000};
    old_lane = wide ? shifted[15:0] : {8'h00, shifted[7:0]};
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    logic lo_hit, hi_hit;
    assign lo_hit = (IDX_W'(g) == idx);
    assign hi_hit = wide && (IDX_W'(g) == idx + IDX_W'(1));
    assign be[g]  = lo_hit || hi_hit;
    assign wdata[8*g +: 8] = lo_hit ? new_lane[7:0] :
                             hi_hit ? new_lane[15:8] : word[8*g +: 8];
  end

endmodule

// File: rtl/subword_amo_unit.sv
module subword_amo_unit #(
  parameter int XLEN   = 64,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32,
  localparam int BYTES = WORD_W / 8,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [4:0]        req_op,
  input  logic [1:0]        req_width,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XLEN-1:0]   req_src,
  input  logic [XLEN-1:0]   req_cmp,
  input  logic              req_aq,
  input  logic              req_rl,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_aq,
  output logic              mem_rl,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [XLEN-1:0]   rsp_data
);
  import amo_pkg::*;

  amo_state_e        state;
  amo_op_e           op_q;
  logic              wide_q, aq_q, rl_q, err_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [15:0]       src_q, cmp_q, old_q;

  logic bad_op, bad_width, misalign, wide_in;
  logic accept, acc_fault, do_write, cas_miss;
  logic [15:0]      old_lane;
  logic [BYTES-1:0] lane_be;
  lane_res_t        calc;
  logic [63:0]      ext64;

  amo_req_check u_chk (
    .op       (req_op),
    .width    (req_width),
    .addr_b0  (req_addr[0]),
    .bad_op   (bad_op),
    .bad_width(bad_width),
    .misalign (misalign),
    .wide     (wide_in)
  );

  amo_lane_path #(.WORD_W(WORD_W)) u_lane (
    .word    (mem_rdata),
    .idx     (idx_q),
    .wide    (wide_q),
    .new_lane(calc.val),
    .old_lane(old_lane),
    .be      (lane_be),
    .wdata   (mem_wdata)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign acc_fault = bad_op || bad_width || misalign;
  assign calc      = lane_calc(op_q, wide_q, old_lane, src_q, cmp_q);
  assign do_write  = (state == ST_WRITE) && calc.wr;
  assign cas_miss  = (state == ST_WRITE) && (op_q == OP_CAS) && !calc.wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_ADD;
      wide_q  <= 1'b0;
      aq_q    <= 1'b0;
      rl_q    <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
      waddr_q <= '0;
      src_q   <= '0;
      cmp_q   <= '0;
      old_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q    <= amo_op_e'(req_op);
          wide_q  <= wide_in;
          aq_q    <= req_aq;
          rl_q    <= req_rl;
          src_q   <= req_src[15:0];
          cmp_q   <= req_cmp[15:0];
          waddr_q <= {req_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
          idx_q   <= wide_in ? {req_addr[IDX_W-1:1], 1'b0} : req_addr[IDX_W-1:0];
          err_q   <= acc_fault;
          old_q   <= '0;
          state   <= acc_fault ? ST_RESP : ST_READ;
        end
        ST_READ:  state <= ST_WRITE;
        ST_WRITE: begin
          old_q <= old_lane;
          state <= ST_RESP;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (state == ST_READ) || do_write;
  assign mem_we   = do_write;
  assign mem_lock = (state == ST_READ) || (state == ST_WRITE);
  assign mem_addr = waddr_q;
  assign mem_be   = mem_req ? lane_be : '0;
  assign mem_aq   = aq_q;
  assign mem_rl   = rl_q;

  assign ext64     = sext_lane(old_q, wide_q);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_data  = err_q ? '0 : XLEN'($signed(ext64));

  // ---------------- assertions ----------------
  a_r9_lock_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);

  a_r9_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we));

  a_r9_single_pulse_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_r7_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !$past(mem_req));

  a_r5_cas_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    cas_miss |-> !mem_req);

  a_r8_lane_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_be) == (wide_q ? 2 : 1)));

  a_r3_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  a_r3_sign_extended: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[XLEN-1:15] == {(XLEN-15){rsp_data[15]}}));

  a_r10_order_bits_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> ($stable(mem_aq) && $stable(mem_rl)));

  a_r4_operands_captured: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (src_q == 16'($past(req_src)) && cmp_q == 16'($past(req_cmp))));

endmodule

// File: tb/sim_subword_amo_unit.sv
module sim_subword_amo_unit;
  localparam int XLEN = 64, WORD_W = 32, ADDR_W = 10, NW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [4:0]        req_op = '0;
  logic [1:0]        req_width = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [XLEN-1:0]   req_src = '0, req_cmp = '0;
  logic              req_aq = 1'b0, req_rl = 1'b0;
  logic              mem_req, mem_we, mem_lock, mem_aq, mem_rl;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0]        mem_be;
  logic [WORD_W-1:0] mem_wdata, mem_rdata;
  logic              rsp_valid, rsp_err;
  logic [XLEN-1:0]   rsp_data;

  subword_amo_unit #(.XLEN(XLEN), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u0 (.*);

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] seed(input int i);
    return 32'h8C3E_71A5 ^ (32'(i) * 32'h1111_0F0F);
  endfunction

  // memory model
  logic [31:0] mem [NW];
  int rd_cnt = 0, wr_cnt = 0;
  logic seen_aq = 1'b0, seen_rl = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= seed(i);
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[5:2]];
        rd_cnt <= rd_cnt + 1;
      end
      seen_aq <= mem_aq;
      seen_rl <= mem_rl;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [63:0] data;
    bit          err;
    int          wi;
    logic [31:0] word;
    int          reads, writes, lat, t0;
    bit          aq, rl;
    string       tag;
  } item_t;
  item_t sb[$];
  logic [31:0] shadow [NW];

  function automatic longint sx(input longint v, input int bits);
    return (v <<< (64 - bits)) >>> (64 - bits);
  endfunction

  function automatic bit legal(input logic [4:0] op);
    return op inside {5'd0, 5'd1, 5'd4, 5'd5, 5'd8, 5'd12, 5'd16, 5'd20, 5'd24, 5'd28};
  endfunction

  task automatic do_amo(input logic [4:0] op, input logic [1:0] wd, input int addr,
                        input logic [63:0] src, input logic [63:0] cmp,
                        input bit aq, input bit rl, input string tag);
    item_t it;
    int bits, sh;
    longint mask, o, s, os, ss, nv;
    bit wr;
    it.wi = (addr >> 2) & (NW - 1);
    it.aq = aq; it.rl = rl; it.tag = tag;
    if (!legal(op) || wd > 1 || (wd == 1 && addr[0])) begin
      it.err = 1; it.data = '0; it.reads = 0; it.writes = 0; it.lat = 1;
    end else begin
      bits = (wd == 1) ? 16 : 8;
      sh   = (wd == 1) ? (addr & 2) * 8 : (addr & 3) * 8;
      mask = (64'd1 << bits) - 1;
      o  = (longint'(shadow[it.wi]) >> sh) & mask;
      s  = longint'(src) & mask;
      os = sx(o, bits); ss = sx(s, bits);
      wr = 1;
      case (op)
        5'd0:  nv = (o + s) & mask;
        5'd1:  nv = s;
        5'd4:  nv = o ^ s;
        5'd8:  nv = o | s;
        5'd12: nv = o & s;
        5'd16: nv = (os <= ss) ? o : s;
        5'd20: nv = (os >= ss) ? o : s;
        5'd24: nv = (o <= s) ? o : s;
        5'd28: nv = (o >= s) ? o : s;
        default: begin nv = s; wr = ((longint'(cmp) & mask) == o); end
      endcase
      if (wr)
        shadow[it.wi] = 32'((longint'(shadow[it.wi]) & ~(mask << sh)) | (nv << sh));
      it.err = 0; it.data = 64'(sx(o, bits));
      it.reads = 1; it.writes = wr ? 1 : 0; it.lat = 3;
    end
    it.word = shadow[it.wi];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.t0 = cyc;
    sb.push_back(it);
    req_valid = 1; req_op = op; req_width = wd; req_addr = ADDR_W'(addr);
    req_src = src; req_cmp = cmp; req_aq = aq; req_rl = rl;
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor
  int rd_base = 0, wr_base = 0;
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(0, "R9", "unexpected response", 64'd1, 64'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(rsp_err == it.err, {it.tag, " R6 R7 R2"}, "error flag", 64'(rsp_err), 64'(it.err));
        check(rsp_data == it.data, {it.tag, " R3"}, "result", rsp_data, it.data);
        check(mem[it.wi] == it.word, {it.tag, " R8"}, "memory word", 64'(mem[it.wi]), 64'(it.word));
        check(rd_cnt - rd_base == it.reads, {it.tag, " R9"}, "reads", 64'(rd_cnt - rd_base), 64'(it.reads));
        check(wr_cnt - wr_base == it.writes, {it.tag, " R5 R9"}, "writes", 64'(wr_cnt - wr_base), 64'(it.writes));
        check(cyc - it.t0 == it.lat, {it.tag, " R9"}, "latency", 64'(cyc - it.t0), 64'(it.lat));
        if (it.reads > 0)
          check(seen_aq == it.aq && seen_rl == it.rl, {it.tag, " R10"}, "aq/rl",
                64'({seen_aq, seen_rl}), 64'({it.aq, it.rl}));
        rd_base = rd_cnt; wr_base = wr_cnt;
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) shadow[i] = seed(i);
    repeat (3) @(negedge clk);
    check(req_ready == 1 && rsp_valid == 0 && mem_req == 0, "R9", "reset state",
          64'({req_ready, rsp_valid, mem_req}), 64'(3'b100));
    rst_n = 1;
    // R1 basic ops, lanes of several words
    do_amo(5'd0,  0, 0,  64'h5, 0, 0, 0, "R1 add byte");
    do_amo(5'd1,  0, 1,  64'hFF, 0, 1, 0, "R1 swap byte");
    do_amo(5'd0,  0, 1,  64'h1, 0, 0, 1, "R1 add wrap");
    do_amo(5'd1,  1, 2,  64'h8001, 0, 1, 1, "R1 swap half");
    do_amo(5'd8,  1, 2,  64'h0, 0, 0, 0, "R3 read neg half");
    do_amo(5'd0,  0, 3,  64'hDEADBEEF_CAFE0102, 0, 0, 0, "R4 add upper garbage");
    do_amo(5'd4,  1, 4,  64'hFFFF_0000_5A5A, 0, 0, 0, "R1 xor half");
    do_amo(5'd8,  0, 5,  64'h11, 0, 0, 0, "R1 or byte");
    do_amo(5'd12, 1, 6,  64'hF0F0, 0, 0, 0, "R1 and half");
    // signed vs unsigned min/max
    do_amo(5'd1,  0, 8,  64'h80, 0, 0, 0, "R1 setup");
    do_amo(5'd24, 0, 8,  64'h01, 0, 0, 0, "R3 minu");
    do_amo(5'd28, 0, 8,  64'h80, 0, 0, 0, "R3 maxu");
    do_amo(5'd16, 0, 8,  64'h7F, 0, 0, 0, "R1 min");
    do_amo(5'd20, 0, 8,  64'hFFFF_FF01, 0, 0, 0, "R4 max garbage");
    do_amo(5'd16, 1, 18, 64'h8000, 0, 0, 0, "R1 min half");
    do_amo(5'd28, 1, 16, 64'hFFFF_FFFF_FFFF_7FFF, 0, 0, 0, "R4 maxu half");
    do_amo(5'd20, 0, 9,  64'h7F, 0, 1, 1, "R10 max byte");
    // compare-and-swap
    do_amo(5'd1,  0, 12, 64'h3C, 0, 0, 0, "R1 setup cas");
    do_amo(5'd5,  0, 12, 64'h77, 64'hFFFF_FFFF_FFFF_FF3C, 1, 0, "R5 cas match");
    do_amo(5'd5,  0, 12, 64'h11, 64'h3D, 0, 1, "R5 cas miss");
    do_amo(5'd5,  1, 14, 64'h1234, {48'hABCD_0000_0000, shadow[3][31:16]}, 0, 0, "R5 cas half match");
    do_amo(5'd5,  1, 14, 64'h9999, 64'h0, 0, 0, "R5 cas half miss");
    // faults
    do_amo(5'd0,  1, 9,  64'h1, 0, 0, 0, "R6 misaligned 9");
    do_amo(5'd1,  1, 11, 64'h1, 0, 1, 1, "R6 misaligned 11");
    do_amo(5'd0,  0, 11, 64'h1, 0, 0, 0, "R6 byte odd ok");
    do_amo(5'd2,  0, 20, 64'h1, 0, 0, 0, "R7 illegal 00010");
    do_amo(5'd3,  1, 20, 64'h1, 0, 0, 0, "R7 illegal 00011");
    do_amo(5'd31, 0, 20, 64'h1, 0, 0, 0, "R7 illegal 11111");
    do_amo(5'd0,  2, 20, 64'h1, 0, 0, 0, "R2 width 2");
    do_amo(5'd0,  3, 20, 64'h1, 0, 0, 0, "R2 width 3");
    // every lane of one word
    for (int a = 40; a < 44; a++) do_amo(5'd4, 0, a, 64'hC3, 0, a[0], a[1], "R8 byte lanes");
    for (int a = 44; a < 48; a += 2) do_amo(5'd0, 1, a, 64'h7FFF, 0, 0, 0, "R8 half lanes");
    repeat (8) @(negedge clk);
    check(sb.size() == 0, "R9", "responses outstanding", 64'(sb.size()), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule